// File: doc/BRIEF.md
# Iterative perfect-square root unit

This block returns the integer square root of a 7-bit operand without using a multiplier or a divider. A datapath holds three registers: the loaded operand, a running square and an odd increment. On every iteration the running square grows by the increment, and the increment then grows by two. The running square therefore steps through 1, 4, 9, 16 and so on. The loop stops when the running square reaches the operand. The root is the final increment shifted right by one bit. For example, an operand of 25 ends with an increment of 11 and a root of 5.

A controller with four encodable states sequences the datapath through three strobes: load, add-to-square and add-two-to-increment. The strobes take effect at the clock edge that ends the cycle in which they are raised. For this reason the controller spends one wait cycle after a load before it reads the comparison flags. The user pulses `start` while `ready` is high and collects `root` once `ready` returns. An operand that is zero or not a perfect square cannot hang the unit: it stops as soon as the running square passes the operand.

Top module: `psq_root`

## Requirements
- R1: While `clear` is high at a rising edge, the controller returns to idle, so `ready` is 1 in the following cycle whatever was in progress.
- R2: A `start` seen at a rising edge while `ready` is 1 is accepted, and `ready` is 0 in the very next cycle.
- R3: For a perfect-square operand n*n with 1 <= n <= 11, `root` equals n once `ready` is back at 1.
- R4: For a perfect-square operand with root n, `ready` stays 0 for exactly n+1 cycles: one wait cycle plus n compare cycles, of which n-1 also step the registers.
- R5: For an operand m that is not a perfect square, the unit stops once the running square exceeds m. It returns to idle with `root` equal to the smallest k for which k*k >= m, after k+1 busy cycles.
- R6: An operand of 0 stops at the first compare with `root` = 1, after 2 busy cycles.
- R7: While `ready` is 0, `start` and changes on `operand` are ignored, and the running computation finishes with the result of the operand that was accepted.
- R8: While the unit is idle, `root` holds its value until the next accepted start, whatever `operand` does.
- R9: The widest cases fit the ports. Operand 121 yields 11, and operand 127 yields 12, which is within the 4-bit `root`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear of the controller, active high |
| start | input | 1 | Request to begin a computation, sampled while idle |
| operand | input | 7 | Value whose root is wanted, captured on an accepted start |
| ready | output | 1 | High while idle and able to accept a start |
| root | output | 4 | Final increment shifted right by one bit |

## Verification
Every perfect square from 1 to 121 is run. This shows that the root is correct and that the busy time grows by one cycle per unit of root, which separates an off-by-one stop from a correct one. Non-squares (2, 26, 50, 127) and zero are run to show that the greater-than exit ends the loop and reports the rounded-up root. A second start with a new operand during a run, a clear in the middle of a run, and long idle stretches while the operand toggles show whether the controller ignores what it must ignore and keeps the result steady.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_SPARE = 2'd3
    } psq_state_e;

    typedef struct packed {
        psq_state_e st;
    } psq_ctrl_s;

endpackage

// File: rtl/psq_ctrl.sv
module psq_ctrl
    import psq_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  logic start,
    input  logic hit,
    input  logic over,
    output logic ready,
    output logic load,
    output logic step
);

    psq_ctrl_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        load  = 1'b0;
        step  = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    nxt_d.st = ST_WAIT;
                end
            end
            ST_WAIT: nxt_d.st = ST_RUN;
            ST_RUN: begin
                if (hit || over) nxt_d.st = ST_IDLE;
                else             step = 1'b1;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
        if (clear) begin
            nxt_d.st = ST_IDLE;
            load     = 1'b0;
            step     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign ready = (cur_q.st == ST_IDLE);

    p_clear_idle_r1: assert property (@(posedge clk) clear |=> ready)
        else $error("clear did not return to idle");
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (clear)
        (ready && start) |=> !ready)
        else $error("ready stayed high after start");
    p_stop_on_flag_r4: assert property (@(posedge clk) disable iff (clear)
        (cur_q.st == ST_RUN && (hit || over)) |=> ready)
        else $error("did not stop on flag");
    p_no_wait_flag_r4: assert property (@(posedge clk) disable iff (clear)
        load |=> (cur_q.st == ST_WAIT))
        else $error("load not followed by wait");

endmodule

// File: rtl/psq_dpath.sv
module psq_dpath #(
    parameter int OPW = 7,
    parameter int RW  = 4
) (
    input  logic           clk,
    input  logic           load,
    input  logic           add_sq,
    input  logic           add_inc,
    input  logic [OPW-1:0] operand,
    output logic           hit,
    output logic           over,
    output logic [RW-1:0]  root
);

    localparam int SQW  = OPW + 1;
    localparam int INCW = RW + 1;

    typedef struct packed {
        logic [SQW-1:0]  sq;
        logic [INCW-1:0] inc;
        logic [OPW-1:0]  opd;
    } dp_s;

    dp_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.sq  = SQW'(1);
            nxt_d.inc = INCW'(3);
            nxt_d.opd = operand;
        end else begin
            if (add_sq)  nxt_d.sq  = cur_q.sq + SQW'(cur_q.inc);
            if (add_inc) nxt_d.inc = cur_q.inc + INCW'(2);
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign hit  = (cur_q.sq == SQW'(cur_q.opd));
    assign over = (cur_q.sq >  SQW'(cur_q.opd));
    assign root = RW'(cur_q.inc >> 1);

    p_load_init_r3: assert property (@(posedge clk)
        load |=> (cur_q.sq == SQW'(1) && cur_q.inc == INCW'(3)))
        else $error("load did not initialise registers");
    p_inc_step_r3: assert property (@(posedge clk)
        (add_inc && !load) |=> (cur_q.inc == $past(cur_q.inc) + INCW'(2)))
        else $error("increment did not grow by two");
    p_opd_hold_r7: assert property (@(posedge clk)
        !load |=> $stable(cur_q.opd))
        else $error("operand register changed without load");

endmodule

// File: rtl/psq_root.sv
module psq_root #(
    parameter int OPW = 7,
    parameter int RW  = 4
) (
    input  logic           clk,
    input  logic           clear,
    input  logic           start,
    input  logic [OPW-1:0] operand,
    output logic           ready,
    output logic [RW-1:0]  root
);

    logic load, step, hit, over;

    psq_ctrl u_ctrl (
        .clk   (clk),
        .clear (clear),
        .start (start),
        .hit   (hit),
        .over  (over),
        .ready (ready),
        .load  (load),
        .step  (step)
    );

    psq_dpath #(.OPW(OPW), .RW(RW)) u_dpath (
        .clk     (clk),
        .load    (load),
        .add_sq  (step),
        .add_inc (step),
        .operand (operand),
        .hit     (hit),
        .over    (over),
        .root    (root)
    );

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (clear)
        ready |-> !step)
        else $error("step strobe while idle");
    p_root_stable_r8: assert property (@(posedge clk) disable iff (clear)
        (ready && !start) |=> $stable(root))
        else $error("root moved while idle");

endmodule

// File: tb/psq_root_tb.sv
`timescale 1ns/1ps
module psq_root_tb;

    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       start = 1'b0;
    logic [6:0] operand = '0;
    logic       ready;
    logic [3:0] root;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    psq_root u_dut (
        .clk(clk), .clear(clear), .start(start),
        .operand(operand), .ready(ready), .root(root)
    );

    function automatic int want_root(int m);
        for (int k = 1; k < 16; k++) if (k * k >= m) return k;
        return 15;
    endfunction

    function automatic string class_tag(int m);
        int r = want_root(m);
        if (m == 0) return "R6";
        if (m == 121 || m == 127) return "R9";
        if (r * r == m) return "R3";
        return "R5";
    endfunction

    // reference model
    bit    armed = 0;
    bit    exp_ready = 1;
    bit    root_ok = 0;
    int    cnt = 0;
    int    exp_root = 0;
    int    idle_run = 0;
    string rtag = "R1";
    string ctag = "R3";
    string extra = "";

    always @(posedge clk) begin
        if (clear) begin
            armed <= 1; exp_ready <= 1; cnt <= 0; root_ok <= 0;
            rtag <= "R1"; idle_run <= 0;
        end else if (armed) begin
            if (exp_ready && start) begin
                exp_ready <= 0;
                cnt       <= want_root(int'(operand)) + 1;
                exp_root  <= want_root(int'(operand));
                ctag      <= class_tag(int'(operand));
                root_ok   <= 1;
                rtag      <= "R2";
                idle_run  <= 0;
            end else if (!exp_ready) begin
                rtag <= "R4";
                if (cnt == 1) exp_ready <= 1;
                cnt <= cnt - 1;
            end else begin
                rtag     <= "R8";
                idle_run <= idle_run + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (armed && !clear && !finished) begin
            checks++;
            if (ready !== exp_ready) begin
                errors++;
                $display("FAIL %s ready actual %0b expected %0b", rtag, ready, exp_ready);
            end
            if (exp_ready && root_ok) begin
                checks++;
                if (int'(root) != exp_root) begin
                    errors++;
                    $display("FAIL %s%s root actual %0d expected %0d",
                             (idle_run > 1) ? "R8" : ctag, extra, root, exp_root);
                end
            end
        end
    end

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic do_run(int m);
        wait_ready();
        operand = 7'(m);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        wait_ready();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
        // R3 R4 R9: every perfect square
        for (int n = 1; n <= 11; n++) do_run(n * n);
        // R5 R9 non-squares, R6 zero
        do_run(26); do_run(2); do_run(50); do_run(127); do_run(0);
        // R7: second start and operand change while busy
        wait_ready();
        extra = " R7";
        operand = 7'd49; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); operand = 7'd9; start = 1'b1;
        @(negedge clk); start = 1'b0; operand = 7'd100;
        wait_ready();
        // R8: idle with operand toggling
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); operand = 7'(i * 17);
        end
        extra = "";
        // R1: clear in the middle of a run
        operand = 7'd100; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); @(negedge clk);
        clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        do_run(64);
        do_run(121);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired, actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule